// File: doc/BRIEF.md
# Integer to Float Converter

This block turns an integer held in a 64-bit general register into a value for a 64-bit floating-point register. A 2-bit type code says whether the source is a signed or unsigned word (32 bits) or doubleword (64 bits). A precision select asks for either a double result or a result rounded to single precision and then widened to double format. Rounding follows a 2-bit mode input.

The converter is purely combinational. Next to the result it reports whether rounding incremented the magnitude, whether the result is inexact, and a 5-bit class code for the status register. A word source converted to double is always exact. For that case the block lowers `statusUpdate`, and the surrounding pipeline then leaves its status register alone. Register files, condition-register updates and trapping are handled outside this block.

Top module: `int_to_float`

## Requirements
- R1: Type code 0 selects signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit and 3 unsigned 64-bit. For the two 32-bit codes only `srcReg[31:0]` is read, and bits 63:32 have no effect on any output.
- R2: A 32-bit source with `singleOut`=0 converts exactly to double. `statusUpdate`, `fracRounded`, `fracInexact` and `resultClass` are all 0.
- R3: A 64-bit source, or any source with `singleOut`=1, is rounded with `statusUpdate`=1. `roundMode` 00 rounds to nearest even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Toward zero never increments the magnitude.
- R4: In round-to-nearest, a dropped part of exactly half an ulp rounds to the even significand.
- R5: On the rounded paths `fracRounded` is 1 exactly when the magnitude was incremented. `fracInexact` is 1 exactly when discarded bits were non-zero. `fracInexact`=1 is the request to set the sticky inexact bit, and `fracRounded`=1 implies `fracInexact`=1.
- R6: With `singleOut`=1 the value is rounded to a 24-bit significand and presented in double format, so `result[28:0]` is always 0.
- R7: When `statusUpdate`=1, `resultClass` is 00010 for +0, 00100 for a positive normal and 01000 for a negative normal.
- R8: A zero source gives +0.0 (all result bits 0) with both flags 0.
- R9: A rounding increment that carries out of the significand gives the next power of two, with the exponent raised by one and the fraction zero.
- R10: `result[63]` equals the sign of the selected source. The most negative signed 64-bit value converts exactly to -2^63 (0xC3E0000000000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcReg | input | 64 | Integer register value |
| intType | input | 2 | Source type code (see R1) |
| singleOut | input | 1 | 1: round to single precision, widen to double |
| roundMode | input | 2 | Rounding mode (see R3) |
| result | output | 64 | Double-format result |
| fracRounded | output | 1 | Magnitude was incremented by rounding |
| fracInexact | output | 1 | Result inexact; sets sticky inexact bit |
| resultClass | output | 5 | Result class code, 0 when no status update |
| statusUpdate | output | 1 | Status outputs are to be written |

## Verification
The rounding increment and renormalisation can happen in the same evaluation. This occurs when every kept significand bit is one and the dropped part forces an increment, so the carry has to move the exponent up while it clears the fraction. The bench provokes this with an all-ones unsigned doubleword and with the largest signed word under single precision, in several rounding modes. It judges every result against a quotient-and-remainder model that shares no structure with the guard and sticky logic in the design.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int REG_W    = 64;
  localparam int HALF_W   = REG_W / 2;
  localparam int DBL_FRAC = 52;
  localparam int DBL_EXP  = 11;
  localparam int DBL_BIAS = (1 << (DBL_EXP - 1)) - 1;
  localparam int SGL_FRAC = 23;
  localparam int CLASS_W  = 5;
  localparam int LZ_W     = $clog2(REG_W) + 1;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } roundMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic signedSrc;
    logic wideSrc;
    logic roundPath;
    logic singlePrec;
  } cvtCtl_t;

  localparam logic [CLASS_W-1:0] CLS_NONE     = 5'b00000;
  localparam logic [CLASS_W-1:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [CLASS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLASS_W-1:0] CLS_NEG_NORM = 5'b01000;
endpackage

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import i2f_pkg::*;
(
  input  logic [1:0] intType,
  input  logic       singleOut,
  output cvtCtl_t    ctl
);
  always_comb begin
    ctl.signedSrc  = ~intType[0];
    ctl.wideSrc    = intType[1];
    ctl.singlePrec = singleOut;
    // word to double is exact: no rounding, no status (R2)
    ctl.roundPath  = intType[1] | singleOut;
  end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2f_rounder.sv
module i2f_rounder
  import i2f_pkg::*;
#(
  parameter int W    = 64,
  parameter int FRAC = 52
) (
  input  logic [W-1:0]    norm,
  input  logic            negative,
  input  logic [1:0]      roundMode,
  input  logic            enable,
  output logic [FRAC-1:0] frac,
  output logic            carry,
  output logic            incr,
  output logic            inexact
);
  localparam int DROP  = W - 1 - FRAC;
  localparam int SUM_W = FRAC + 2;

  logic [FRAC:0]    kept;
  logic             guardBit, stickyBit, wantUp;
  logic [SUM_W-1:0] sum;
  logic             unusedLead;

  assign kept      = norm[W-1 -: FRAC+1];
  assign guardBit  = norm[DROP-1];
  assign stickyBit = |norm[DROP-2:0];

  always_comb begin
    case (roundMode_e'(roundMode))
      RM_NEAREST: wantUp = guardBit & (stickyBit | kept[0]);
      RM_ZERO:    wantUp = 1'b0;
      RM_UP:      wantUp = ~negative & (guardBit | stickyBit);
      default:    wantUp = negative & (guardBit | stickyBit);
    endcase
    incr    = enable & wantUp;
    inexact = enable & (guardBit | stickyBit);
  end

  assign sum        = {1'b0, kept} + SUM_W'(incr);
  assign carry      = sum[FRAC+1];
  assign frac       = sum[FRAC-1:0];
  assign unusedLead = sum[FRAC];
endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import i2f_pkg::*;
(
  input  logic [REG_W-1:0]   srcReg,
  input  cvtCtl_t            ctl,
  input  logic [1:0]         roundMode,
  output logic [REG_W-1:0]   result,
  output logic               fracRounded,
  output logic               fracInexact,
  output logic [CLASS_W-1:0] resultClass,
  output logic               statusUpdate
);
  logic [REG_W-1:0]    extended, magnitude, normed;
  logic                negative, isZero;
  logic [LZ_W-1:0]     leadZeros;
  logic [DBL_FRAC-1:0] dblFrac, fracField;
  logic [SGL_FRAC-1:0] sglFrac;
  logic                dblCarry, sglCarry, dblInc, sglInc, dblInx, sglInx, pickCarry;
  logic [DBL_EXP-1:0]  expField;

  always_comb begin
    if (ctl.wideSrc) extended = srcReg;
    else extended = {{HALF_W{ctl.signedSrc & srcReg[HALF_W-1]}}, srcReg[HALF_W-1:0]};
    negative  = ctl.signedSrc & extended[REG_W-1];
    magnitude = negative ? (~extended + REG_W'(1)) : extended;
  end

  i2f_lzc #(.W(REG_W), .CW(LZ_W)) i_lzc (.val(magnitude), .count(leadZeros));

  assign isZero = (leadZeros == LZ_W'(REG_W));
  assign normed = magnitude << leadZeros;

  i2f_rounder #(.W(REG_W), .FRAC(DBL_FRAC)) i_rndDbl (
    .norm(normed), .negative(negative), .roundMode(roundMode),
    .enable(ctl.roundPath & ~ctl.singlePrec),
    .frac(dblFrac), .carry(dblCarry), .incr(dblInc), .inexact(dblInx)
  );

  i2f_rounder #(.W(REG_W), .FRAC(SGL_FRAC)) i_rndSgl (
    .norm(normed), .negative(negative), .roundMode(roundMode),
    .enable(ctl.singlePrec),
    .frac(sglFrac), .carry(sglCarry), .incr(sglInc), .inexact(sglInx)
  );

  always_comb begin
    pickCarry = ctl.singlePrec ? sglCarry : dblCarry;
    expField  = DBL_EXP'(DBL_BIAS + REG_W - 1) - DBL_EXP'(leadZeros) + DBL_EXP'(pickCarry);
    fracField = ctl.singlePrec ? {sglFrac, {(DBL_FRAC - SGL_FRAC){1'b0}}} : dblFrac;
    result    = isZero ? '0 : {negative, expField, fracField};

    statusUpdate = ctl.roundPath;
    fracRounded  = ctl.singlePrec ? sglInc : dblInc;
    fracInexact  = ctl.singlePrec ? sglInx : dblInx;

    if (!ctl.roundPath) resultClass = CLS_NONE;
    else if (isZero)    resultClass = CLS_POS_ZERO;
    else if (negative)  resultClass = CLS_NEG_NORM;
    else                resultClass = CLS_POS_NORM;
  end
endmodule

// File: rtl/int_to_float.sv
module int_to_float
  import i2f_pkg::*;
(
  input  logic [REG_W-1:0]   srcReg,
  input  logic [1:0]         intType,
  input  logic               singleOut,
  input  logic [1:0]         roundMode,
  output logic [REG_W-1:0]   result,
  output logic               fracRounded,
  output logic               fracInexact,
  output logic [CLASS_W-1:0] resultClass,
  output logic               statusUpdate
);
  cvtCtl_t ctl;

  i2f_ctrl i_ctrl (.intType(intType), .singleOut(singleOut), .ctl(ctl));

  i2f_datapath i_dp (
    .srcReg(srcReg), .ctl(ctl), .roundMode(roundMode),
    .result(result), .fracRounded(fracRounded), .fracInexact(fracInexact),
    .resultClass(resultClass), .statusUpdate(statusUpdate)
  );
endmodule

// File: rtl/int_to_float_chk.sv
module int_to_float_chk (
  input logic [63:0] srcReg,
  input logic [1:0]  intType,
  input logic        singleOut,
  input logic [1:0]  roundMode,
  input logic [63:0] result,
  input logic        fracRounded,
  input logic        fracInexact,
  input logic [4:0]  resultClass,
  input logic        statusUpdate
);
  logic srcNeg, srcZero;

  always_comb begin
    srcNeg  = intType[1] ? (~intType[0] & srcReg[63]) : (~intType[0] & srcReg[31]);
    srcZero = intType[1] ? (srcReg == 64'd0) : (srcReg[31:0] == 32'd0);

    if (!intType[1] && !singleOut)
      a_r2_bypass_quiet: assert (!statusUpdate && !fracRounded && !fracInexact && resultClass == 5'b0);
    if (fracRounded)
      a_r5_rounded_is_inexact: assert (fracInexact);
    if (roundMode == 2'b01)
      a_r3_toward_zero_no_increment: assert (!fracRounded);
    if (singleOut)
      a_r6_single_low_bits_clear: assert (result[28:0] == 29'd0);
    if (srcZero)
      a_r8_zero_gives_plus_zero: assert (result == 64'd0 && !fracRounded && !fracInexact);
    a_r10_sign_follows_source: assert (result[63] == srcNeg);
    if (statusUpdate)
      a_r7_class_legal: assert (resultClass == 5'b00010 || resultClass == 5'b00100 || resultClass == 5'b01000);
  end
endmodule

bind int_to_float int_to_float_chk i_chk (
  .srcReg(srcReg), .intType(intType), .singleOut(singleOut), .roundMode(roundMode),
  .result(result), .fracRounded(fracRounded), .fracInexact(fracInexact),
  .resultClass(resultClass), .statusUpdate(statusUpdate)
);

// File: tb/test_int_to_float.sv
module test_int_to_float;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10ns clk = ~clk;

  logic [63:0] srcReg = '0;
  logic [1:0]  intType = '0;
  logic        singleOut = 1'b0;
  logic [1:0]  roundMode = '0;
  logic [63:0] result;
  logic        fracRounded, fracInexact, statusUpdate;
  logic [4:0]  resultClass;

  int errors = 0;
  int checks = 0;

  int_to_float i_int_to_float (
    .srcReg(srcReg), .intType(intType), .singleOut(singleOut), .roundMode(roundMode),
    .result(result), .fracRounded(fracRounded), .fracInexact(fracInexact),
    .resultClass(resultClass), .statusUpdate(statusUpdate)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        fr;
    logic        fi;
    logic [4:0]  cls;
    logic        upd;
  } exp_t;

  // behavioural model: quotient / remainder against a power of two
  function automatic exp_t model(logic [63:0] r, logic [1:0] it, logic sgl, logic [1:0] rm);
    exp_t e;
    longint unsigned mag, q, rem, half, mask, frac;
    logic neg, up;
    int top, fb, sh;
    e = '0; neg = 1'b0; up = 1'b0; rem = 0; half = 0; top = 0;
    case (it)
      2'd0: begin neg = r[31]; mag = {{32{r[31]}}, r[31:0]}; if (neg) mag = -mag; end
      2'd1: mag = {32'd0, r[31:0]};
      2'd2: begin neg = r[63]; mag = r; if (neg) mag = -mag; end
      default: mag = r;
    endcase
    e.upd = it[1] | sgl;
    if (mag == 0) begin
      e.cls = e.upd ? 5'b00010 : 5'b00000;
      return e;
    end
    for (int i = 0; i < 64; i++) if (mag[i]) top = i;
    fb = sgl ? 23 : 52;
    if (top <= fb) q = mag << (fb - top);
    else begin
      sh = top - fb;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = 64'd1 << (sh - 1);
    end
    if (e.upd) begin
      case (rm)
        2'd0: up = (rem > half) || (rem != 0 && rem == half && q[0]);
        2'd1: up = 1'b0;
        2'd2: up = !neg && rem != 0;
        default: up = neg && rem != 0;
      endcase
      e.fr = up;
      e.fi = (rem != 0);
    end
    if (up) q = q + 1;
    if (q == (64'd1 << (fb + 1))) begin q = q >> 1; top = top + 1; end
    mask = (64'd1 << fb) - 1;
    frac = (q & mask) << (52 - fb);
    e.res = {neg, 11'(1023 + top), frac[51:0]};
    e.cls = e.upd ? (neg ? 5'b01000 : 5'b00100) : 5'b00000;
    return e;
  endfunction

  task automatic apply(input logic [63:0] r, input logic [1:0] it, input logic sgl,
                       input logic [1:0] rm, input string tag);
    exp_t ex;
    @(posedge clk);
    srcReg = r; intType = it; singleOut = sgl; roundMode = rm;
    @(negedge clk);
    ex = model(r, it, sgl, rm);
    checks++;
    if (result !== ex.res || fracRounded !== ex.fr || fracInexact !== ex.fi ||
        resultClass !== ex.cls || statusUpdate !== ex.upd) begin
      errors++;
      $display("FAIL %s: src=%h type=%0d sgl=%0d rm=%0d actual res=%h fr=%b fi=%b cls=%b upd=%b expected res=%h fr=%b fi=%b cls=%b upd=%b",
               tag, r, it, sgl, rm, result, fracRounded, fracInexact, resultClass, statusUpdate,
               ex.res, ex.fr, ex.fi, ex.cls, ex.upd);
    end
  endtask

  // hand-computed anchor on the value applied last (sampled in the same low phase)
  task automatic anchor(input logic [63:0] want, input string tag);
    checks++;
    if (result !== want) begin
      errors++;
      $display("FAIL %s anchor: actual %h expected %h", tag, result, want);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    apply(64'd0, 2'd0, 1'b0, 2'd0, "R8");                       anchor(64'd0, "R8");
    apply(64'd0, 2'd2, 1'b0, 2'd2, "R8");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 2'd0, "R2");     anchor(64'hBFF0_0000_0000_0000, "R2");
    apply(64'hDEAD_BEEF_FFFF_FFFF, 2'd1, 1'b0, 2'd3, "R1");     anchor(64'h41EF_FFFF_FFE0_0000, "R1");
    apply(64'h1234_5678_FFFF_FFFF, 2'd0, 1'b1, 2'd0, "R1");
    apply(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0, "R10");    anchor(64'hC3E0_0000_0000_0000, "R10");
    apply(-64'd5, 2'd2, 1'b0, 2'd0, "R7");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0, "R9");     anchor(64'h43F0_0000_0000_0000, "R9");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1, "R3");     anchor(64'h43EF_FFFF_FFFF_FFFF, "R3");
    apply(64'h0020_0000_0000_0001, 2'd2, 1'b0, 2'd0, "R4");     anchor(64'h4340_0000_0000_0000, "R4");
    apply(64'h0020_0000_0000_0003, 2'd2, 1'b0, 2'd0, "R4");     anchor(64'h4340_0000_0000_0002, "R4");
    apply(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'd0, "R6");     anchor(64'h4170_0000_0000_0000, "R6");
    apply(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'd2, "R3");     anchor(64'h4170_0000_2000_0000, "R3");
    apply(64'h0000_0000_FEFF_FFFF, 2'd0, 1'b1, 2'd3, "R3");     anchor(64'hC170_0000_2000_0000, "R3");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'd2, "R9");     anchor(64'h43F0_0000_0000_0000, "R9");
    apply(64'h0000_0000_7FFF_FFFF, 2'd0, 1'b1, 2'd0, "R9");     anchor(64'h41E0_0000_0000_0000, "R9");

    // sweep: every type, precision and mode, magnitudes spread over all binades
    for (int n = 0; n < 4000; n++) begin
      r = {$urandom, $urandom};
      r = r >> ($urandom % 64);
      if (n % 5 == 0) r = -r;
      apply(r, 2'($urandom % 4), 1'($urandom % 2), 2'($urandom % 4), "R5");
    end

    summary();
  end
endmodule